// File: doc/BRIEF.md
# Queued Two-Transfer Conversion Sequencer

This block is a free-running serial master that paces an external sampling converter without host software in the loop. It runs a fixed two-entry transfer queue. The first entry is a short 8-clock transfer. During it, the convert strobe and the chip select are both driven low, and that starts a conversion. The second entry is a 16-clock transfer. Only the chip select is low during it, and the converter's result is shifted in most significant bit first. After each transfer, a programmable quiet interval keeps both selects high and the serial clock low. When the second interval ends, the queue wraps to the first entry, so the sample rate comes only from the system clock and two run-time settings.

The serial clock idles low, and the received bit is captured when it rises. Each high phase and each low phase lasts `clk_div + 1` system cycles. The quiet interval lasts `post_delay + 1` cycles. Each completed 16-bit word is presented on `result` with a one-cycle `result_valid` strobe. The `enable` input is honoured only at the queue's wrap point, so a conversion that has been started is always read out before the sequencer goes idle.

Top module: `csq_conv_sequencer`

## Requirements
- R1: After reset, `cs_n` and `conv_n` are 1, `sclk` is 0, `result_valid` is 0 and `result` is 0.
- R2: While idle with `enable` at 0, no transfer begins and `cs_n` stays 1.
- R3: The start transfer drives `conv_n` and `cs_n` to 0 together for exactly 8 rising edges of `sclk`. `conv_n` is never 0 while `cs_n` is 1.
- R4: The read transfer holds `conv_n` at 1 and `cs_n` at 0 for exactly 16 rising edges of `sclk`. It always directly follows a start transfer, and `conv_n` does not change while `cs_n` stays 0.
- R5: `sclk` is 0 whenever `cs_n` is 1. Inside a transfer, each high phase and each low phase lasts `clk_div + 1` cycles, so a transfer of N bits keeps `cs_n` at 0 for N·2·(`clk_div` + 1) cycles.
- R6: `miso` is captured on each rising edge of `sclk` during the read transfer. The first captured bit is `result[15]` and the last is `result[0]`.
- R7: `result_valid` is 1 for exactly one cycle: the first cycle with `cs_n` at 1 after a read transfer. In that cycle, `result` holds the captured word. `result` does not change in any other cycle.
- R8: After each transfer, both selects stay at 1 for exactly `post_delay + 1` cycles before the next transfer, provided the sequence keeps running.
- R9: While `enable` stays 1, the quiet interval after a read transfer is followed by a new start transfer with no further input.
- R10: If `enable` goes to 0 at any point, the sequence completes the pending read transfer and its quiet interval, then stays idle. Starts and reads end up equal in number.
- R11: `clk_div` is taken when a transfer begins and `post_delay` is taken when a quiet interval begins. Changing either one in between does not alter the interval already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; sampled at the queue wrap point and when idle |
| clk_div | input | 8 | Serial clock half-period, minus one, in system cycles |
| post_delay | input | 16 | Quiet interval after each transfer, minus one, in system cycles |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| conv_n | output | 1 | Active-low convert strobe, low only during the start transfer |
| cs_n | output | 1 | Active-low chip select, low during both transfers |
| result | output | 16 | Last received conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new word on `result` |

## Verification
A wrong queue position shows at the next opening of `cs_n`, and it shows at the ports. Two start transfers in a row, or a read that begins without a start before it, are visible at once, and a missed convert strobe is caught within one quiet interval. A bit counter that is off by one changes the number of `sclk` rising edges and the width of the `cs_n` low window. A shifter that is out of step corrupts the word reported in the same cycle as `result_valid`. A stale copy of the divider or delay setting changes a phase width or a gap length inside the very interval that used it.

// File: rtl/csq_pkg.sv
package csq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_GAP_A,
        SQ_READ,
        SQ_GAP_B
    } sq_state_e;

    function automatic logic sq_is_xfer(sq_state_e s);
        return (s == SQ_START) || (s == SQ_READ);
    endfunction

endpackage

// File: rtl/csq_sclk_gen.sv
module csq_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             active,
    input  logic [DIV_W-1:0] div_in,
    output logic             sclk,
    output logic             rise_now,
    output logic             fall_now
);

    typedef struct packed {
        logic             sclk;
        logic [DIV_W-1:0] half;
        logic [DIV_W-1:0] div;
    } gen_t;

    gen_t s_d, s_q;
    logic edge_due;

    always_comb begin
        s_d      = s_q;
        edge_due = (s_q.half == s_q.div);
        rise_now = active && !s_q.sclk && edge_due;
        fall_now = active &&  s_q.sclk && edge_due;
        if (load) begin
            s_d.sclk = 1'b0;
            s_d.half = '0;
            s_d.div  = div_in;
        end else if (active) begin
            if (edge_due) begin
                s_d.sclk = !s_q.sclk;
                s_d.half = '0;
            end else begin
                s_d.half = s_q.half + DIV_W'(1);
            end
        end else begin
            s_d.sclk = 1'b0;
            s_d.half = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk = s_q.sclk;

endmodule

// File: rtl/csq_shift_in.sv
module csq_shift_in #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             din,
    output logic [WIDTH-1:0] word
);

    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (sample) sh_d = {sh_q[WIDTH-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word = sh_q;

endmodule

// File: rtl/csq_gap_timer.sv
module csq_gap_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] len,
    output logic             done
);

    typedef struct packed {
        logic             run;
        logic [DLY_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d  = t_q;
        done = t_q.run && (t_q.cnt == '0);
        if (load) begin
            t_d.run = 1'b1;
            t_d.cnt = len;
        end else if (t_q.run) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - DLY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/csq_conv_sequencer.sv
module csq_conv_sequencer
    import csq_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int DLY_W      = 16,
    parameter int START_BITS = 8,
    parameter int READ_BITS  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [DIV_W-1:0]     clk_div,
    input  logic [DLY_W-1:0]     post_delay,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 conv_n,
    output logic                 cs_n,
    output logic [READ_BITS-1:0] result,
    output logic                 result_valid
);

    localparam int MAX_BITS = (READ_BITS > START_BITS) ? READ_BITS : START_BITS;
    localparam int CNT_W    = (MAX_BITS > 2) ? $clog2(MAX_BITS) : 1;
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_BITS - 1);
    localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(READ_BITS - 1);

    typedef struct packed {
        sq_state_e            state;
        logic [CNT_W-1:0]     bit_cnt;
        logic [READ_BITS-1:0] result;
        logic                 valid;
    } seq_t;

    seq_t st_d, st_q;

    logic                 gen_load, gap_load, gap_done;
    logic                 rise_now, fall_now, xfer_active;
    logic [READ_BITS-1:0] rx_word;

    assign xfer_active = sq_is_xfer(st_q.state);

    csq_sclk_gen #(.DIV_W(DIV_W)) i_sclk_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gen_load),
        .active   (xfer_active),
        .div_in   (clk_div),
        .sclk     (sclk),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    csq_shift_in #(.WIDTH(READ_BITS)) i_shift_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (rise_now && (st_q.state == SQ_READ)),
        .din    (miso),
        .word   (rx_word)
    );

    csq_gap_timer #(.DLY_W(DLY_W)) i_gap_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .len   (post_delay),
        .done  (gap_done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        gen_load   = 1'b0;
        gap_load   = 1'b0;
        case (st_q.state)
            SQ_IDLE: begin
                if (enable) begin
                    st_d.state   = SQ_START;
                    st_d.bit_cnt = '0;
                    gen_load     = 1'b1;
                end
            end
            SQ_START: begin
                if (fall_now) begin
                    if (st_q.bit_cnt == START_LAST) begin
                        st_d.state = SQ_GAP_A;
                        gap_load   = 1'b1;
                    end else begin
                        st_d.bit_cnt = st_q.bit_cnt + CNT_W'(1);
                    end
                end
            end
            SQ_GAP_A: begin
                if (gap_done) begin
                    st_d.state   = SQ_READ;
                    st_d.bit_cnt = '0;
                    gen_load     = 1'b1;
                end
            end
            SQ_READ: begin
                if (fall_now) begin
                    if (st_q.bit_cnt == READ_LAST) begin
                        st_d.state  = SQ_GAP_B;
                        st_d.result = rx_word;
                        st_d.valid  = 1'b1;
                        gap_load    = 1'b1;
                    end else begin
                        st_d.bit_cnt = st_q.bit_cnt + CNT_W'(1);
                    end
                end
            end
            SQ_GAP_B: begin
                if (gap_done) begin
                    if (enable) begin
                        st_d.state   = SQ_START;
                        st_d.bit_cnt = '0;
                        gen_load     = 1'b1;
                    end else begin
                        st_d.state = SQ_IDLE;
                    end
                end
            end
            default: st_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state   <= SQ_IDLE;
            st_q.bit_cnt <= '0;
            st_q.result  <= '0;
            st_q.valid   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n         = !xfer_active;
    assign conv_n       = (st_q.state != SQ_START);
    assign result       = st_q.result;
    assign result_valid = st_q.valid;

endmodule

// File: rtl/csq_conv_sequencer_chk.sv
module csq_conv_sequencer_chk #(
    parameter int READ_BITS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk,
    input logic                 conv_n,
    input logic                 cs_n,
    input logic [READ_BITS-1:0] result,
    input logic                 result_valid
);

    // R3: convert strobe only inside a selected window
    p_conv_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_n |-> !cs_n);

    // R5: serial clock rests low between transfers
    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4: transfer kind fixed while selected
    p_kind_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> (conv_n == $past(conv_n)));

    // R7: strobe lasts one cycle
    p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R7: strobe marks the close of a read transfer
    p_valid_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (cs_n && $past(!cs_n) && conv_n && $past(conv_n)));

    // R7: word held between strobes
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

endmodule

bind csq_conv_sequencer csq_conv_sequencer_chk #(.READ_BITS(READ_BITS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .conv_n       (conv_n),
    .cs_n         (cs_n),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/test_csq_conv_sequencer.sv
`timescale 1ns/1ps
module test_csq_conv_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic [15:0] post_delay = 16'd3;
    logic        miso = 1'b0;
    logic        sclk, conv_n, cs_n, result_valid;
    logic [15:0] result;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    csq_conv_sequencer i_csq_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
        .post_delay(post_delay), .miso(miso), .sclk(sclk), .conv_n(conv_n),
        .cs_n(cs_n), .result(result), .result_valid(result_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // directed words first, then random
    int word_idx = 0;
    function automatic logic [15:0] next_word(int idx);
        case (idx)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h0001;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic int bits_of(logic c);
        return c ? 16 : 8;
    endfunction

    // monitor and converter model, sampled on the falling clock edge
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;
    logic [7:0]  prev_div = 8'd1;
    logic [15:0] prev_dly = 16'd3;
    logic        win_conv = 1'b1;
    int rises = 0, low_len = 0, hi_len = 0, exp_h = 1;
    int gap_cnt = 0, exp_gap = 0, last_kind = 0, bit_k = 0;
    int n_starts = 0, n_reads = 0;
    bit en_dropped = 1'b0;
    logic [15:0] cur_word = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && prev_cs) begin
                if (last_kind == 1 || (last_kind == 2 && !en_dropped))
                    chk(gap_cnt == exp_gap + 1, "R8", "gap length", gap_cnt, exp_gap + 1);
                if (!conv_n) begin
                    chk(last_kind != 1, "R9", "start after start", last_kind, 2);
                    n_starts++;
                end else begin
                    chk(last_kind == 1, "R4", "read without start", last_kind, 1);
                    n_reads++;
                    cur_word = next_word(word_idx);
                    word_idx++;
                    bit_k = 0;
                    miso = cur_word[15];
                end
                win_conv = conv_n;
                rises = 0; low_len = 0; hi_len = 0;
                exp_h = int'(prev_div) + 1;
            end
            if (!cs_n) begin
                low_len++;
                if (sclk && !prev_sclk) rises++;
            end
            if (sclk) hi_len++;
            if (!sclk && prev_sclk) begin
                chk(hi_len == exp_h, "R5", "high phase", hi_len, exp_h);
                hi_len = 0;
                if (win_conv) begin
                    bit_k++;
                    if (bit_k < 16) miso = cur_word[15 - bit_k];
                end
            end
            if (cs_n && !prev_cs) begin
                chk(rises == bits_of(win_conv), win_conv ? "R4" : "R3", "sclk rises",
                    rises, bits_of(win_conv));
                chk(low_len == bits_of(win_conv) * 2 * exp_h, "R5", "window length",
                    low_len, bits_of(win_conv) * 2 * exp_h);
                if (win_conv) begin
                    chk(result_valid == 1'b1, "R7", "valid at read end", result_valid, 1);
                    chk(result == cur_word, "R6", "captured word", result, cur_word);
                    last_kind = 2;
                end else begin
                    chk(result_valid == 1'b0, "R7", "valid after start", result_valid, 0);
                    last_kind = 1;
                    miso = 1'($urandom);
                end
                gap_cnt = 0;
                exp_gap = int'(prev_dly);
                en_dropped = 1'b0;
            end else if (result_valid) begin
                chk(1'b0, "R7", "stray valid", 1, 0);
            end
            if (cs_n) gap_cnt++;
            if (!enable) en_dropped = 1'b1;
            if (!cs_n && !conv_n && !sclk && prev_sclk) miso = 1'($urandom);
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
        prev_div  = clk_div;
        prev_dly  = post_delay;
    end

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int snap;
        void'($urandom(32'd12345));
        cycles(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1,   "R1", "cs_n after reset", cs_n, 1);
        chk(conv_n == 1'b1, "R1", "conv_n after reset", conv_n, 1);
        chk(sclk == 1'b0,   "R1", "sclk after reset", sclk, 0);
        chk(result_valid == 1'b0 && result == 16'h0, "R1", "result after reset",
            {result_valid, result}, 0);
        cycles(60);
        @(negedge clk);
        chk(n_starts == 0 && cs_n == 1'b1, "R2", "idle with enable low", n_starts, 0);

        // directed: fastest clock and shortest gap
        cycles(1);
        clk_div = 8'd0; post_delay = 16'd0; enable = 1'b1;
        while (n_reads < 2 || !cs_n) @(negedge clk);
        cycles(1);
        clk_div = 8'd3; post_delay = 16'd10;
        while (n_reads < 5) @(negedge clk);

        // random settings changed at arbitrary moments (R11)
        while (n_reads < 40) begin
            cycles(int'($urandom_range(1, 400)));
            clk_div    = 8'($urandom_range(0, 3));
            post_delay = 16'($urandom_range(0, 24));
        end

        // stop request during a start transfer (R10)
        @(negedge clk);
        while (!(cs_n == 1'b0 && conv_n == 1'b0)) @(negedge clk);
        cycles(1);
        enable = 1'b0;
        cycles(1500);
        @(negedge clk);
        chk(n_starts == n_reads, "R10", "start/read balance", n_starts, n_reads);
        chk(cs_n == 1'b1, "R10", "idle after stop", cs_n, 1);
        snap = n_starts;
        cycles(300);
        chk(n_starts == snap, "R10", "no new start", n_starts, snap);

        // restart and wrap without intervention (R9)
        enable = 1'b1;
        snap = n_reads;
        while (n_reads < snap + 3) @(negedge clk);
        chk(n_starts >= snap + 3, "R9", "wrapped conversions", n_starts, snap + 3);

        // stop request during the gap after a start (R10)
        while (!(last_kind == 1 && cs_n == 1'b1)) @(negedge clk);
        cycles(1);
        enable = 1'b0;
        cycles(1500);
        @(negedge clk);
        chk(n_starts == n_reads, "R10", "read completes after gap stop", n_starts, n_reads);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule